// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Product Shift

This block is a single-issue multiply-accumulate datapath. Each accepted operation multiplies two 32-bit operands and either adds the product to one of four 40-bit accumulators or subtracts it from that accumulator. The arithmetic is set by a mode field in a small status register: signed integer, unsigned integer or signed fractional. Word-size operations use a 16-bit half of each operand.

Before accumulation, an integer product can be shifted left or right by one bit. Each kind of shift has its own fill rule. Fractional products are always aligned by a fixed left shift, and any requested shift is ignored for them.

Each accumulator keeps a sticky overflow flag. When the overflow-mode control bit is set, that flag stops further accumulation into the same accumulator. An overflow status bit reports the outcome of the most recent operation.

Operations are presented on a valid/operand/control port. Results appear two clock edges later with a one-cycle done pulse. The accumulators are visible through a combinational read port, and the status register is written and read through a simple register port.

Top module: `mac_shift_unit`

## Requirements
- R1: After reset, all four accumulators read zero, the status register reads 0x00, and done is low.
- R2: Status register layout:
  - bits [1:0] hold the mode: 00 is signed integer, 01 is unsigned integer, 10 or 11 is signed fractional.
  - bit 2 is the overflow-mode control.
  - bit 3 is the overflow status bit.
  - bits [7:4] are the sticky flags of accumulators 0 to 3, in that order.
  - A write loads every field.
- R3: With in_word=1, in_hi_x and in_hi_y each select bits 31:16 of their operand when 1 and bits 15:0 when 0. The selected half is sign-extended in the signed modes and zero-extended in unsigned mode. A word integer product never flags product overflow.
- R4: in_shift encodes 01 as left by one, 10 as right by one, and 00 or 11 as no shift. The shift is applied to the 40-bit product before it is added or subtracted. A left shift inserts 0 at bit 0. It flags product overflow when bit 39 changes (signed) or when a 1 is shifted out (unsigned).
- R5: A right shift fills bit 39 as follows:
  - with 0 in unsigned mode;
  - with the product sign for signed word operations;
  - for signed longword operations, with the product sign, except that the fill is 0 when the 32x32 product overflowed 40 bits.
- R6: In fractional mode, in_shift has no effect. The accumulated value is bits [63:31] of the full product, sign-extended to 40 bits. Fractional operations never flag product overflow.
- R7: A longword integer product that does not fit in 40 bits (signed or unsigned range, by mode) flags product overflow, and its low 40 bits are used.
- R8: in_sub=1 subtracts and in_sub=0 adds. Accumulation overflow is flagged when the signed result leaves the 40-bit signed range, or on an unsigned carry or borrow.
- R9: If the control bit and the target accumulator's sticky flag are both set, the accumulator is left unchanged and the status bit reads 1. Otherwise the sticky flag is cleared, then set if the product or the accumulation overflowed. After every operation the status bit equals the target's sticky flag.
- R10: done is high for exactly one cycle, two clock edges after an accepted operation. Operations may be issued on consecutive cycles. Cycles with in_valid low change nothing.
- R11: in_acc selects the target accumulator 0 to 3, and the other accumulators are not changed. rd_sel selects the accumulator shown on rd_acc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| in_x | input | 32 | First operand |
| in_y | input | 32 | Second operand |
| in_sub | input | 1 | 1 subtracts product, 0 adds |
| in_word | input | 1 | 1 selects word-size operands |
| in_hi_x | input | 1 | Upper-half select for in_x |
| in_hi_y | input | 1 | Upper-half select for in_y |
| in_shift | input | 2 | Product shift code |
| in_acc | input | 2 | Target accumulator index |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status register write data |
| stat_rdata | output | 8 | Status register contents |
| rd_sel | input | 2 | Accumulator read select |
| rd_acc | output | 40 | Selected accumulator value |
| done | output | 1 | Operation completed |
| ovf | output | 1 | Overflow status bit |

## Verification
The hardest case to reach is the zero fill of a signed right shift. It only occurs when a longword product overflows 40 bits while its truncated bit 39 is 1. The stimulus produces this with 0x7FFFFFFF squared.

Gating is also hard to reach. It needs a sticky flag already set while the control bit is on. That flag comes from an earlier left shift that pushes 2^38 past bit 39. After that, the bench shows both a blocked accumulator and an unblocked neighbour, and then clears the flag through a status write.

Signed accumulation overflow without product overflow is reached by adding 2^38 twice.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam logic [1:0] SHIFT_LEFT  = 2'b01;
  localparam logic [1:0] SHIFT_RIGHT = 2'b10;

  typedef struct packed {
    logic is_signed;
    logic is_frac;
  } arith_t;

  function automatic arith_t decode_mode(input logic [1:0] mode);
    arith_t a;
    a.is_frac   = mode[1];
    a.is_signed = ~(~mode[1] & mode[0]);
    return a;
  endfunction
endpackage

// File: rtl/mac_operand_sel.sv
module mac_operand_sel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              word,
  input  logic              hi,
  input  logic              sgn,
  output logic [DATA_W:0]   ext
);
  localparam int HALF_W = DATA_W / 2;
  localparam int PAD_W  = DATA_W + 1 - HALF_W;

  logic [HALF_W-1:0] half;

  always_comb begin
    half = hi ? raw[DATA_W-1:HALF_W] : raw[HALF_W-1:0];
    if (word) begin
      ext = {{PAD_W{sgn & half[HALF_W-1]}}, half};
    end else begin
      ext = {sgn & raw[DATA_W-1], raw};
    end
  end
endmodule

// File: rtl/mac_product_stage.sv
module mac_product_stage
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40,
  parameter int IDX_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DATA_W:0]  ex,
  input  logic [DATA_W:0]  ey,
  input  logic             word,
  input  logic             is_signed,
  input  logic             is_frac,
  input  logic [1:0]       shift,
  input  logic             sub,
  input  logic [IDX_W-1:0] idx,
  output logic             s1_valid,
  output logic [ACC_W-1:0] s1_prod,
  output logic             s1_povf,
  output logic             s1_sub,
  output logic             s1_signed,
  output logic [IDX_W-1:0] s1_idx
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int XPAD_W = PROD_W - DATA_W - 1;
  localparam int FPAD_W = ACC_W - DATA_W - 1;

  logic [PROD_W-1:0] xw, yw, pf;
  logic [ACC_W-1:0]  p_int, p_frac, p_shift, prod_d;
  logic              long_ovf, left_ovf, fill, povf_d;

  assign xw = {{XPAD_W{ex[DATA_W]}}, ex};
  assign yw = {{XPAD_W{ey[DATA_W]}}, ey};
  assign pf = xw * yw;

  always_comb begin
    p_int  = pf[ACC_W-1:0];
    p_frac = {{FPAD_W{pf[PROD_W-1]}}, pf[PROD_W-1:DATA_W-1]};
    if (is_signed) begin
      long_ovf = ~((&pf[PROD_W-1:ACC_W-1]) | ~(|pf[PROD_W-1:ACC_W-1]));
      left_ovf = p_int[ACC_W-1] ^ p_int[ACC_W-2];
    end else begin
      long_ovf = |pf[PROD_W-1:ACC_W];
      left_ovf = p_int[ACC_W-1];
    end
    if (word) long_ovf = 1'b0;
    fill = is_signed & ~(~word & long_ovf) & p_int[ACC_W-1];
    p_shift = p_int;
    povf_d  = long_ovf;
    if (shift == SHIFT_LEFT) begin
      p_shift = {p_int[ACC_W-2:0], 1'b0};
      povf_d  = long_ovf | left_ovf;
    end else if (shift == SHIFT_RIGHT) begin
      p_shift = {fill, p_int[ACC_W-1:1]};
    end
    if (is_frac) begin
      prod_d = p_frac;
      povf_d = 1'b0;
    end else begin
      prod_d = p_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_prod   <= '0;
      s1_povf   <= 1'b0;
      s1_sub    <= 1'b0;
      s1_signed <= 1'b0;
      s1_idx    <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_prod   <= prod_d;
        s1_povf   <= povf_d;
        s1_sub    <= sub;
        s1_signed <= is_signed;
        s1_idx    <= idx;
      end
    end
  end

  a_r6_frac_no_povf: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_frac) |=> !s1_povf);
  a_r3_word_no_povf: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && word) |=> !s1_povf);
endmodule

// File: rtl/mac_accum_bank.sv
module mac_accum_bank #(
  parameter int ACC_W   = 40,
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_valid,
  input  logic [ACC_W-1:0]         op_prod,
  input  logic                     op_povf,
  input  logic                     op_sub,
  input  logic                     op_signed,
  input  logic [IDX_W-1:0]         op_idx,
  input  logic                     wr_en,
  input  logic [1:0]               wr_mode,
  input  logic                     wr_omc,
  input  logic                     wr_v,
  input  logic [NUM_ACC-1:0]       wr_sticky,
  output logic [1:0]               mode_q,
  output logic                     omc_q,
  output logic                     v_q,
  output logic [NUM_ACC-1:0]       sticky_q,
  output logic                     done_q,
  output logic [NUM_ACC*ACC_W-1:0] acc_flat
);
  logic [ACC_W-1:0]   cur;
  logic [ACC_W:0]     a_ext, b_ext, sum;
  logic               acc_ovf, blocked;
  logic [1:0]         mode_d;
  logic               omc_d, v_d;
  logic [NUM_ACC-1:0] sticky_d, acc_we;

  assign cur   = acc_flat[op_idx*ACC_W +: ACC_W];
  assign a_ext = {op_signed & cur[ACC_W-1], cur};
  assign b_ext = {op_signed & op_prod[ACC_W-1], op_prod};
  assign sum   = op_sub ? (a_ext - b_ext) : (a_ext + b_ext);
  assign acc_ovf = op_signed ? (sum[ACC_W] ^ sum[ACC_W-1]) : sum[ACC_W];
  assign blocked = omc_q & sticky_q[op_idx];

  always_comb begin
    mode_d   = wr_en ? wr_mode   : mode_q;
    omc_d    = wr_en ? wr_omc    : omc_q;
    v_d      = wr_en ? wr_v      : v_q;
    sticky_d = wr_en ? wr_sticky : sticky_q;
    acc_we   = '0;
    if (op_valid) begin
      if (blocked) begin
        sticky_d[op_idx] = 1'b1;
        v_d              = 1'b1;
      end else begin
        sticky_d[op_idx] = op_povf | acc_ovf;
        v_d              = op_povf | acc_ovf;
        acc_we[op_idx]   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      omc_q    <= 1'b0;
      v_q      <= 1'b0;
      sticky_q <= '0;
      done_q   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      omc_q    <= omc_d;
      v_q      <= v_d;
      sticky_q <= sticky_d;
      done_q   <= op_valid;
    end
  end

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic [ACC_W-1:0] acc_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_r <= '0;
      end else if (acc_we[g]) begin
        acc_r <= sum[ACC_W-1:0];
      end
    end
    assign acc_flat[g*ACC_W +: ACC_W] = acc_r;
  end

  a_r9_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && omc_q && sticky_q[op_idx]) |=> ($stable(acc_flat) && v_q));
endmodule

// File: rtl/mac_shift_unit.sv
module mac_shift_unit
  import mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ACC_W   = 40,
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = $clog2(NUM_ACC),
  parameter int STAT_W  = 4 + NUM_ACC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_x,
  input  logic [DATA_W-1:0] in_y,
  input  logic              in_sub,
  input  logic              in_word,
  input  logic              in_hi_x,
  input  logic              in_hi_y,
  input  logic [1:0]        in_shift,
  input  logic [IDX_W-1:0]  in_acc,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [STAT_W-1:0] stat_rdata,
  input  logic [IDX_W-1:0]  rd_sel,
  output logic [ACC_W-1:0]  rd_acc,
  output logic              done,
  output logic              ovf
);
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  logic [1:0]               mode_q;
  logic                     omc_q, v_q;
  logic [NUM_ACC-1:0]       sticky_q;
  logic [NUM_ACC*ACC_W-1:0] acc_flat;
  arith_t                   ar;

  assign ar = decode_mode(mode_q);

  logic [DATA_W-1:0] raw_op [2];
  logic              hi_op  [2];
  logic [DATA_W:0]   ext_op [2];
  assign raw_op[0] = in_x;
  assign raw_op[1] = in_y;
  assign hi_op[0]  = in_hi_x;
  assign hi_op[1]  = in_hi_y;

  for (genvar i = 0; i < 2; i++) begin : g_opsel
    mac_operand_sel #(.DATA_W(DATA_W)) u_sel (
      .raw (raw_op[i]),
      .word(in_word),
      .hi  (hi_op[i]),
      .sgn (ar.is_signed),
      .ext (ext_op[i])
    );
  end

  logic             s1_valid, s1_povf, s1_sub, s1_signed;
  logic [ACC_W-1:0] s1_prod;
  logic [IDX_W-1:0] s1_idx;

  mac_product_stage #(.DATA_W(DATA_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_prod (
    .clk      (clk),
    .rst_n    (rst_ns),
    .in_valid (in_valid),
    .ex       (ext_op[0]),
    .ey       (ext_op[1]),
    .word     (in_word),
    .is_signed(ar.is_signed),
    .is_frac  (ar.is_frac),
    .shift    (in_shift),
    .sub      (in_sub),
    .idx      (in_acc),
    .s1_valid (s1_valid),
    .s1_prod  (s1_prod),
    .s1_povf  (s1_povf),
    .s1_sub   (s1_sub),
    .s1_signed(s1_signed),
    .s1_idx   (s1_idx)
  );

  mac_accum_bank #(.ACC_W(ACC_W), .NUM_ACC(NUM_ACC), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_ns),
    .op_valid (s1_valid),
    .op_prod  (s1_prod),
    .op_povf  (s1_povf),
    .op_sub   (s1_sub),
    .op_signed(s1_signed),
    .op_idx   (s1_idx),
    .wr_en    (stat_we),
    .wr_mode  (stat_wdata[1:0]),
    .wr_omc   (stat_wdata[2]),
    .wr_v     (stat_wdata[3]),
    .wr_sticky(stat_wdata[STAT_W-1:4]),
    .mode_q   (mode_q),
    .omc_q    (omc_q),
    .v_q      (v_q),
    .sticky_q (sticky_q),
    .done_q   (done),
    .acc_flat (acc_flat)
  );

  assign stat_rdata = {sticky_q, v_q, omc_q, mode_q};
  assign ovf        = v_q;
  assign rd_acc     = acc_flat[rd_sel*ACC_W +: ACC_W];

  a_r10_done_after_two: assert property (@(posedge clk) disable iff (!rst_ns)
    in_valid |-> ##2 done);
  a_r10_idle_no_done: assert property (@(posedge clk) disable iff (!rst_ns)
    !in_valid |-> ##2 !done);
endmodule

// File: tb/mac_shift_unit_tb.sv
module mac_shift_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sub, in_word, in_hi_x, in_hi_y, stat_we;
  logic [31:0] in_x, in_y;
  logic [1:0]  in_shift, in_acc, rd_sel;
  logic [7:0]  stat_wdata, stat_rdata;
  logic [39:0] rd_acc;
  logic        done, ovf;
  int          total = 0;
  int          bad   = 0;

  always #10 clk = ~clk;

  mac_shift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_sub(in_sub), .in_word(in_word), .in_hi_x(in_hi_x), .in_hi_y(in_hi_y),
    .in_shift(in_shift), .in_acc(in_acc), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .rd_sel(rd_sel),
    .rd_acc(rd_acc), .done(done), .ovf(ovf)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] x;
    logic [31:0] y;
    logic        word;
    logic        hx;
    logic        hy;
    logic [1:0]  sh;
    logic        sub;
    logic [39:0] exp_acc;
    logic        exp_v;
  } vec_t;

  // All vectors target accumulator 1; expected values are cumulative.
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 32'd3,          32'd5,          1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 40'd15,           1'b0},
    '{2'd0, 32'hFFFE_0007, 32'h0000_0003, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 40'd3,            1'b0},
    '{2'd1, 32'h0000_FFFF, 32'h0002_0000, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 40'hFF_FFFF_0004, 1'b1},
    '{2'd0, 32'hFFFF_FFFF, 32'd7,          1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 40'hFF_FFFF_0000, 1'b0},
    '{2'd2, 32'h4000_0000, 32'h4000_0000, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 40'h00_1FFF_0000, 1'b0},
    '{2'd2, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 40'hFF_9FFF_0000, 1'b0},
    '{2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 40'h7F_1FFF_0000, 1'b1},
    '{2'd0, 32'h0000_FFFF, 32'h0000_0003, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 40'h7F_1FFE_FFFE, 1'b0},
    '{2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 40'hFE_1FFE_FFFE, 1'b1},
    '{2'd1, 32'h8000_0000, 32'h0000_0002, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 40'hFE_1FFC_FFFE, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_stat(input logic [7:0] d);
    stat_we    = 1'b1;
    stat_wdata = d;
    @(negedge clk);
    stat_we = 1'b0;
  endtask

  // Returns at the negedge after the second rising edge, when done is due.
  task automatic do_op(input logic [1:0] acc, input logic [31:0] x, input logic [31:0] y,
                       input logic word, input logic hx, input logic hy,
                       input logic [1:0] sh, input logic sub);
    in_valid = 1'b1; in_acc = acc; in_x = x; in_y = y;
    in_word = word; in_hi_x = hx; in_hi_y = hy; in_shift = sh; in_sub = sub;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 done pulse", {63'd0, done}, 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_x = '0; in_y = '0; in_sub = 1'b0;
    in_word = 1'b0; in_hi_x = 1'b0; in_hi_y = 1'b0; in_shift = '0; in_acc = '0;
    stat_we = 1'b0; stat_wdata = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 status", {56'd0, stat_rdata}, 64'h00);
    chk("R1 done", {63'd0, done}, 64'd0);
    for (int a = 0; a < 4; a++) begin
      rd_sel = a[1:0];
      #1;
      chk("R1 accumulator", {24'd0, rd_acc}, 64'd0);
    end

    // Vector table (R3 R4 R5 R6 R7 R8)
    rd_sel = 2'd1;
    for (int i = 0; i < NV; i++) begin
      wr_stat({6'd0, VEC[i].mode});
      do_op(2'd1, VEC[i].x, VEC[i].y, VEC[i].word, VEC[i].hx, VEC[i].hy, VEC[i].sh, VEC[i].sub);
      chk("R3/R4/R5/R6/R7/R8 accumulator", {24'd0, rd_acc}, {24'd0, VEC[i].exp_acc});
      chk("R7/R8 overflow bit", {63'd0, ovf}, {63'd0, VEC[i].exp_v});
    end

    // R9 gating: control bit on, left shift of 2^38 overflows into sticky
    wr_stat(8'h04);
    rd_sel = 2'd2;
    do_op(2'd2, 32'h0008_0000, 32'h0008_0000, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0);
    chk("R4 left shift overflow value", {24'd0, rd_acc}, 64'h80_0000_0000);
    chk("R4 left shift overflow bit", {63'd0, ovf}, 64'd1);
    chk("R2 status sticky layout", {56'd0, stat_rdata}, 64'h4C);
    do_op(2'd2, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    chk("R9 blocked accumulator unchanged", {24'd0, rd_acc}, 64'h80_0000_0000);
    chk("R9 blocked overflow bit", {63'd0, ovf}, 64'd1);
    rd_sel = 2'd3;
    do_op(2'd3, 32'd2, 32'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    chk("R11 neighbour accumulates", {24'd0, rd_acc}, 64'd6);
    chk("R9 neighbour overflow bit", {63'd0, ovf}, 64'd0);
    rd_sel = 2'd1;
    #1;
    chk("R11 other accumulator untouched", {24'd0, rd_acc}, 64'hFE_1FFC_FFFE);
    wr_stat(8'h04);
    rd_sel = 2'd2;
    do_op(2'd2, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    chk("R9 cleared sticky accumulates", {24'd0, rd_acc}, 64'h80_0000_0001);
    chk("R9 overflow bit after clear", {63'd0, ovf}, 64'd0);

    // R8 signed accumulation overflow without product overflow
    wr_stat(8'h00);
    rd_sel = 2'd0;
    do_op(2'd0, 32'h0008_0000, 32'h0008_0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    chk("R8 first add", {24'd0, rd_acc}, 64'h40_0000_0000);
    chk("R8 first add overflow bit", {63'd0, ovf}, 64'd0);
    do_op(2'd0, 32'h0008_0000, 32'h0008_0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    chk("R8 second add wraps", {24'd0, rd_acc}, 64'h80_0000_0000);
    chk("R8 signed overflow bit", {63'd0, ovf}, 64'd1);
    chk("R9 sticky of acc0 set", {63'd0, stat_rdata[4]}, 64'd1);

    // R10 back-to-back issue into accumulator 3 (holds 6)
    rd_sel = 2'd3;
    in_valid = 1'b1; in_acc = 2'd3; in_x = 32'd1; in_y = 32'd10;
    in_word = 1'b0; in_shift = 2'd0; in_sub = 1'b0;
    @(negedge clk);
    in_y = 32'd100;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 first done", {63'd0, done}, 64'd1);
    chk("R10 first result", {24'd0, rd_acc}, 64'd16);
    @(negedge clk);
    chk("R10 second done", {63'd0, done}, 64'd1);
    chk("R10 second result", {24'd0, rd_acc}, 64'd116);

    // R10 idle cycles change nothing
    in_x = 32'hFFFF_FFFF; in_y = 32'hFFFF_FFFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 no done while idle", {63'd0, done}, 64'd0);
    end
    chk("R10 idle accumulator held", {24'd0, rd_acc}, 64'd116);

    // R2 full status write and readback
    wr_stat(8'hFF);
    chk("R2 status readback", {56'd0, stat_rdata}, 64'hFF);
    wr_stat(8'h00);
    chk("R2 status cleared", {56'd0, stat_rdata}, 64'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule